// File: doc/BRIEF.md
# RC Oscillator Frequency Trim Loop

This block closes a digital loop around an on-chip RC oscillator. It runs in the RC clock domain and counts that clock over the interval between two pulses of a slow reference tick. The tick is a single-cycle pulse that has already been brought into the RC domain. Each completed interval gives a measured count, which is compared with a programmed target. If the count lies above the target plus an upper margin, or below the target minus a lower margin, the 8-bit tuning code that drives the oscillator moves by one step. The two margins are set separately. A higher code is taken to mean a faster oscillator, and so a larger count.

Software starts and stops the loop with a run control. A separate enable allows or blocks code updates while measurements continue. An invert control reverses the step direction for oscillators whose trim slope is the other way round. A bypass control places the programmed code on the output while the loop keeps working in the background. The loop starts from the programmed code each time it is started. The code saturates at both ends of its range and never wraps.

Top module: `rc_trim_loop`

## Requirements
- R1: After reset, `code_o` and `meas_cnt_o` are both 0.
- R2: On any clock edge where `start_i` is 0, the interval counter, the measured count and the calculated code are cleared. `meas_cnt_o` then reads 0, and `code_o` reads 0 unless bypass is set.
- R3: On the first clock edge where `start_i` is 1 after being 0, the calculated code loads `prog_code_i`. It is visible on `code_o` after that edge.
- R4: The first `ref_tick_i` after start only opens an interval. Each later tick closes an interval. At that edge `meas_cnt_o` takes the number of clock edges since the previous tick. A tick spacing of N edges reports N. The count saturates at 4095.
- R5: With enable set and invert clear, a measured count greater than `target_cnt_i + hyst_pos_i` lowers the code by 1. The change appears one edge after `meas_cnt_o` updates.
- R6: With enable set and invert clear, a measured count for which `meas + hyst_neg_i < target_cnt_i` raises the code by 1, with the same timing as R5.
- R7: A count inside the band, with both limits inclusive, leaves the code unchanged. In closed loop, the count settles within the band.
- R8: With `invert_i` set, the step directions of R5 and R6 are swapped.
- R9: With `enable_i` clear, the code holds, but measurements are still taken and reported.
- R10: With `bypass_i` set, `code_o` equals `prog_code_i`. The calculated code keeps updating and appears again when bypass is cleared.
- R11: The code stays at 0 when a down step is requested at 0, and stays at 255 when an up step is requested at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RC oscillator clock (the counting domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run control; 0 stops the loop and clears its state |
| enable_i | input | 1 | Allows code updates |
| bypass_i | input | 1 | Places the programmed code on the output |
| invert_i | input | 1 | Reverses the step direction |
| prog_code_i | input | 8 | Programmed tuning code |
| hyst_pos_i | input | 4 | Margin above the target |
| hyst_neg_i | input | 4 | Margin below the target |
| target_cnt_i | input | 12 | Target count per reference interval |
| ref_tick_i | input | 1 | Synchronised single-cycle reference pulse |
| code_o | output | 8 | Tuning code in use |
| meas_cnt_o | output | 12 | Last measured interval count |

## Verification
Two situations are hard to reach from the ports: the code pinned at either end of its range, and the measured count clipped at its 12-bit ceiling. In both, the loop must keep asking for steps or keep counting well past the point where the result changes. The bench reaches the code limits by restarting the loop from a programmed code two or three steps from an end. It then holds the tick spacing far from the target, so that every window requests a step in the same direction. It reaches the count ceiling by spacing ticks more than 4095 edges apart. A behavioural oscillator model, with interval length set by the code, drives the closed-loop case to check that the loop settles.

// File: rtl/rtk_pkg.sv
package rtk_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/rtk_window_counter.sv
module rtk_window_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] meas_o,
    output logic             valid_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] meas;
        logic             armed;
        logic             valid;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d       = win_q;
        win_d.valid = 1'b0;
        if (!run_i) begin
            win_d = '0;
        end else if (tick_i) begin
            if (win_q.armed) begin
                win_d.meas  = win_q.cnt;
                win_d.valid = 1'b1;
            end
            win_d.armed = 1'b1;
            win_d.cnt   = CNT_ONE;
        end else if (win_q.cnt != CNT_MAX) begin
            win_d.cnt = win_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign meas_o  = win_q.meas;
    assign valid_o = win_q.valid;

endmodule

// File: rtl/rtk_step_decide.sv
module rtk_step_decide
    import rtk_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int HYST_W = 4
) (
    input  logic [CNT_W-1:0]  meas_i,
    input  logic [CNT_W-1:0]  target_i,
    input  logic [HYST_W-1:0] hyst_pos_i,
    input  logic [HYST_W-1:0] hyst_neg_i,
    input  logic              invert_i,
    output step_e             step_o
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] upper_lim;
    logic [EXT_W-1:0] meas_plus;
    logic             too_high;
    logic             too_low;

    always_comb begin
        upper_lim = {1'b0, target_i} + EXT_W'(hyst_pos_i);
        meas_plus = {1'b0, meas_i} + EXT_W'(hyst_neg_i);
        too_high  = {1'b0, meas_i} > upper_lim;
        too_low   = meas_plus < {1'b0, target_i};
        step_o    = STEP_HOLD;
        if (too_high)     step_o = invert_i ? STEP_UP : STEP_DOWN;
        else if (too_low) step_o = invert_i ? STEP_DOWN : STEP_UP;
    end

endmodule

// File: rtl/rtk_code_reg.sv
module rtk_code_reg
    import rtk_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              apply_i,
    input  step_e             step_i,
    input  logic [CODE_W-1:0] prog_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MIN = '0;
    localparam logic [CODE_W-1:0] CODE_ONE = {{(CODE_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              run_seen;
    } creg_t;

    creg_t cr_d, cr_q;

    always_comb begin
        cr_d          = cr_q;
        cr_d.run_seen = run_i;
        if (!run_i) begin
            cr_d.code = CODE_MIN;
        end else if (!cr_q.run_seen) begin
            cr_d.code = prog_i;
        end else if (apply_i) begin
            case (step_i)
                STEP_UP:   if (cr_q.code != CODE_MAX) cr_d.code = cr_q.code + CODE_ONE;
                STEP_DOWN: if (cr_q.code != CODE_MIN) cr_d.code = cr_q.code - CODE_ONE;
                default:   cr_d.code = cr_q.code;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    assign code_o = cr_q.code;

endmodule

// File: rtl/rc_trim_loop.sv
module rc_trim_loop
    import rtk_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 12,
    parameter int HYST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              enable_i,
    input  logic              bypass_i,
    input  logic              invert_i,
    input  logic [CODE_W-1:0] prog_code_i,
    input  logic [HYST_W-1:0] hyst_pos_i,
    input  logic [HYST_W-1:0] hyst_neg_i,
    input  logic [CNT_W-1:0]  target_cnt_i,
    input  logic              ref_tick_i,
    output logic [CODE_W-1:0] code_o,
    output logic [CNT_W-1:0]  meas_cnt_o
);
    logic [CNT_W-1:0]  win_meas;
    logic              win_valid;
    step_e             step_req;
    logic              step_apply;
    logic [CODE_W-1:0] calc_code;

    rtk_window_counter #(.CNT_W(CNT_W)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (start_i),
        .tick_i  (ref_tick_i),
        .meas_o  (win_meas),
        .valid_o (win_valid)
    );

    rtk_step_decide #(.CNT_W(CNT_W), .HYST_W(HYST_W)) u_decide (
        .meas_i     (win_meas),
        .target_i   (target_cnt_i),
        .hyst_pos_i (hyst_pos_i),
        .hyst_neg_i (hyst_neg_i),
        .invert_i   (invert_i),
        .step_o     (step_req)
    );

    rtk_code_reg #(.CODE_W(CODE_W)) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (start_i),
        .apply_i (step_apply),
        .step_i  (step_req),
        .prog_i  (prog_code_i),
        .code_o  (calc_code)
    );

    always_comb begin
        step_apply = win_valid & enable_i;
        code_o     = bypass_i ? prog_code_i : calc_code;
        meas_cnt_o = win_meas;
    end

endmodule

// File: rtl/rtk_checks.sv
module rtk_checks #(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              enable_i,
    input logic [CODE_W-1:0] prog_code_i,
    input logic [CODE_W-1:0] calc_code,
    input logic [CNT_W-1:0]  meas_cnt_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_ONE = {{(CODE_W-1){1'b0}}, 1'b1};

    logic run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= start_i;
    end

    a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (meas_cnt_o == '0 && calc_code == '0));

    a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !run_q) |=> (calc_code == $past(prog_code_i)));

    a_r9_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && run_q && !enable_i) |=> $stable(calc_code));

    a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && run_q) |=> (calc_code == $past(calc_code)
                                || calc_code == $past(calc_code) + CODE_ONE
                                || calc_code == $past(calc_code) - CODE_ONE));

    a_r11_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && run_q && calc_code == CODE_MAX) |=> (calc_code != '0));

    a_r11_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && run_q && calc_code == '0) |=> (calc_code != CODE_MAX));

endmodule

bind rc_trim_loop rtk_checks #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .enable_i    (enable_i),
    .prog_code_i (prog_code_i),
    .calc_code   (calc_code),
    .meas_cnt_o  (meas_cnt_o)
);

// File: tb/test_rc_trim_loop.sv
module test_rc_trim_loop;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_SAT    = 4095;
    localparam int WDOG_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        enable_i = 1'b0;
    logic        bypass_i = 1'b0;
    logic        invert_i = 1'b0;
    logic [7:0]  prog_code_i = '0;
    logic [3:0]  hyst_pos_i = '0;
    logic [3:0]  hyst_neg_i = '0;
    logic [11:0] target_cnt_i = '0;
    logic        ref_tick_i = 1'b0;
    logic [7:0]  code_o;
    logic [11:0] meas_cnt_o;

    rc_trim_loop i_rc_trim_loop (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .enable_i(enable_i),
        .bypass_i(bypass_i), .invert_i(invert_i), .prog_code_i(prog_code_i),
        .hyst_pos_i(hyst_pos_i), .hyst_neg_i(hyst_neg_i),
        .target_cnt_i(target_cnt_i), .ref_tick_i(ref_tick_i),
        .code_o(code_o), .meas_cnt_o(meas_cnt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_code = 0, m_meas = 0, m_cnt = 0;
    bit m_armed = 0, m_valid = 0, m_prev = 0;

    // reference tick source
    int fix_period = 0;
    bit osc_mode = 0;
    int gap = 0;

    always @(posedge clk) begin
        int nc;
        bit hi, lo, up;
        if (!rst_n) begin
            m_code = 0; m_meas = 0; m_cnt = 0; m_armed = 0; m_valid = 0; m_prev = 0;
        end else begin
            if (!start_i) begin
                m_code = 0; m_meas = 0; m_cnt = 0; m_armed = 0; m_valid = 0;
            end else begin
                nc = m_code;
                if (!m_prev) nc = int'(prog_code_i);
                else if (m_valid && enable_i) begin
                    hi = m_meas > int'(target_cnt_i) + int'(hyst_pos_i);
                    lo = m_meas + int'(hyst_neg_i) < int'(target_cnt_i);
                    if (hi || lo) begin
                        up = lo;
                        if (invert_i) up = !up;
                        if (up && nc < 255) nc = nc + 1;
                        else if (!up && nc > 0) nc = nc - 1;
                    end
                end
                m_code  = nc;
                m_valid = 0;
                if (ref_tick_i) begin
                    if (m_armed) begin m_meas = m_cnt; m_valid = 1; end
                    m_armed = 1;
                    m_cnt   = 1;
                end else if (m_cnt < CNT_SAT) m_cnt = m_cnt + 1;
            end
            m_prev = start_i;
        end
    end

    // oscillator stand-in: interval length grows with the code
    always @(negedge clk) begin
        ref_tick_i = 1'b0;
        if (osc_mode || fix_period > 0) begin
            gap = gap + 1;
            if (gap >= (osc_mode ? 20 + m_code / 4 : fix_period)) begin
                ref_tick_i = 1'b1;
                gap = 0;
            end
        end else gap = 0;
    end

    function automatic void chk(string req, string what, int act, int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endfunction

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) begin
                chk(cur_req, "code", int'(code_o), bypass_i ? int'(prog_code_i) : m_code);
                chk(cur_req, "meas", int'(meas_cnt_o), m_meas);
            end
        end
    endtask

    task automatic restart(int prog);
        start_i = 1'b0;
        cyc(2);
        prog_code_i = 8'(prog);
        start_i = 1'b1;
        cyc(1);
        chk("R3", "loaded code", int'(code_o), prog);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual %0d cycles expected below %0d", cycles, WDOG_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int c0;
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk("R1", "reset code", int'(code_o), 0);
        chk("R1", "reset meas", int'(meas_cnt_o), 0);
        rst_n = 1'b1;
        cyc(3);

        // R3 / R4: load on start, interval measurement
        cur_req = "R4";
        target_cnt_i = 12'd60; hyst_pos_i = 4'd3; hyst_neg_i = 4'd3;
        fix_period = 50;
        restart(100);
        cyc(200);
        chk("R4", "interval count", int'(meas_cnt_o), 50);
        chk("R9", "code without enable", int'(code_o), 100);

        // R5: count too high lowers the code
        cur_req = "R5";
        enable_i = 1'b1; fix_period = 80;
        cyc(800);
        chk("R5", "code lowered", int'(code_o < 8'd100), 1);

        // R6: count too low raises the code
        cur_req = "R6";
        c0 = int'(code_o); fix_period = 40;
        cyc(800);
        chk("R6", "code raised", int'(int'(code_o) > c0), 1);

        // R7: counts on both inclusive limits hold
        cur_req = "R7";
        fix_period = 63;
        cyc(200);
        c0 = int'(code_o);
        cyc(400);
        chk("R7", "upper limit hold", int'(code_o), c0);
        fix_period = 57;
        cyc(200);
        c0 = int'(code_o);
        cyc(400);
        chk("R7", "lower limit hold", int'(code_o), c0);

        // R8: invert swaps direction
        cur_req = "R8";
        invert_i = 1'b1; fix_period = 80;
        c0 = int'(code_o);
        cyc(800);
        chk("R8", "inverted raise", int'(int'(code_o) > c0), 1);
        invert_i = 1'b0;

        // R9: disabled loop holds but still measures
        cur_req = "R9";
        enable_i = 1'b0; fix_period = 30;
        cyc(100);
        c0 = int'(code_o);
        cyc(400);
        chk("R9", "hold code", int'(code_o), c0);
        chk("R9", "still measuring", int'(meas_cnt_o), 30);

        // R10: bypass forces programmed code, loop runs behind it
        cur_req = "R10";
        enable_i = 1'b1; prog_code_i = 8'd33; bypass_i = 1'b1;
        cyc(2);
        chk("R10", "bypass code", int'(code_o), 33);
        cyc(300);
        bypass_i = 1'b0;
        cyc(2);
        chk("R10", "released code", int'(int'(code_o) > c0), 1);

        // R11: saturation at both ends
        cur_req = "R11";
        target_cnt_i = 12'd10; hyst_pos_i = 4'd0; hyst_neg_i = 4'd0; fix_period = 200;
        restart(2);
        cyc(1400);
        chk("R11", "floor", int'(code_o), 0);
        target_cnt_i = 12'd200; fix_period = 10;
        restart(253);
        cyc(200);
        chk("R11", "ceiling", int'(code_o), 255);

        // R4: count ceiling
        cur_req = "R4";
        enable_i = 1'b0; fix_period = 4200;
        cyc(9000);
        chk("R4", "count ceiling", int'(meas_cnt_o), CNT_SAT);

        // R7: closed loop settles in band
        cur_req = "R7";
        fix_period = 0; osc_mode = 1'b1; enable_i = 1'b1;
        target_cnt_i = 12'd60; hyst_pos_i = 4'd1; hyst_neg_i = 4'd1;
        restart(100);
        cyc(5000);
        chk("R7", "settled in band",
            int'(meas_cnt_o >= 12'd59 && meas_cnt_o <= 12'd61), 1);

        // R2: stopping clears state
        cur_req = "R2";
        start_i = 1'b0;
        cyc(2);
        chk("R2", "stopped code", int'(code_o), 0);
        chk("R2", "stopped meas", int'(meas_cnt_o), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule